// File: doc/BRIEF.md
# RTC Alarm Match Interrupt Unit

This unit watches a running calendar time kept in BCD (seconds, minutes, hours, date, month and day of week). It raises an alarm when that time agrees with a set of six programmable alarm fields. Each alarm field carries its own enable bit, and only the enabled fields take part in the comparison. The timekeeper supplies a one-cycle strobe each time the time advances. The comparison is made only on that strobe, so an alarm that keeps matching fires once per advance and no more.

Two interrupt styles are offered, chosen by a mode input:

- **Single-event.** A match sets a sticky alarm flag, and the active-low interrupt follows that flag until software clears it. Software clears the flag by writing the status location. It can also clear the flag by reading the status location, if the auto-clear option is on.
- **Repeating pulse.** Every match drives the interrupt low for a fixed number of clock cycles, whether or not the flag has been serviced. The flag is still set on each match.

Alarm fields are programmed and read back through a small register port.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `alm_o` is 0, `irq_n_o` is 1, and all six alarm registers read 0x00.
- R2: Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, and 6 status. In an alarm register, bit 7 is the enable and bits 6:0 are the BCD value. A written byte reads back unchanged on `reg_rdata_o`. Address 6 reads as `{7'b0, alm}`.
- R3: A match needs every enabled field to equal its time input. Disabled fields are ignored. With no field enabled, nothing ever matches.
- R4: A match is evaluated only in a cycle where `tick_i` is 1. `alm_o` becomes 1 in the cycle after that strobe. A matching time without the strobe does nothing.
- R5: With `pulse_mode_i`=0, a match sets `alm_o`=1 and `irq_n_o`=0. Both hold until a clearing access.
- R6: A write to address 6 with bit 0 = 0 clears `alm_o`. A write with bit 0 = 1 has no effect on it.
- R7: With `auto_clr_i`=1, a `reg_rd_i` access at address 6 clears `alm_o`. With `auto_clr_i`=0, such a read leaves `alm_o` unchanged.
- R8: With `pulse_mode_i`=1, each match drives `irq_n_o` low for exactly PULSE_CYCLES cycles, starting in the cycle after the strobe. This repeats on every later match, even if `alm_o` was never cleared.
- R9: With `pulse_mode_i`=1, a match still sets `alm_o` to 1.
- R10: A match in the same cycle as a clearing write or read leaves `alm_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe: time has advanced |
| now_sec_i | input | FIELD_W | Current seconds, BCD |
| now_min_i | input | FIELD_W | Current minutes, BCD |
| now_hour_i | input | FIELD_W | Current hours, BCD |
| now_date_i | input | FIELD_W | Current date, BCD |
| now_mon_i | input | FIELD_W | Current month, BCD |
| now_dow_i | input | FIELD_W | Current day of week, BCD |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect on status only) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | FIELD_W+1 | Write data |
| reg_rdata_o | output | FIELD_W+1 | Read data for `reg_addr_i` |
| pulse_mode_i | input | 1 | 0 single-event, 1 repeating pulse |
| auto_clr_i | input | 1 | Status read clears the alarm flag |
| alm_o | output | 1 | Alarm status flag |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Some properties are checked by assertions on every cycle:

- The flag rises only after a strobe.
- A match always sets the flag, even when a clear arrives in the same cycle.
- The flag stays set unless a clearing access arrives.
- Clearing writes and auto-clearing reads take effect in the next cycle.
- In pulse mode, a match starts a low interrupt that never runs longer than PULSE_CYCLES.

The bench scenarios cover the rest:

- Which field combinations count as a match, including fields that are disabled and the case where no field is enabled.
- Register readback.
- That a write of 1 to the status bit has no effect.
- The exact pulse width.
- That a pulse repeats on a later match while the flag is still set.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int NUM_FIELDS = 6;
   localparam int ADDR_W     = 3;

   typedef enum logic [ADDR_W-1:0] {
      SLOT_SEC    = 3'd0,
      SLOT_MIN    = 3'd1,
      SLOT_HOUR   = 3'd2,
      SLOT_DATE   = 3'd3,
      SLOT_MON    = 3'd4,
      SLOT_DOW    = 3'd5,
      SLOT_STATUS = 3'd6,
      SLOT_NONE   = 3'd7
   } slot_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
   parameter int FIELD_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FIELD_W:0]   wdata,
   input  logic [FIELD_W-1:0] cur,
   output logic [FIELD_W:0]   reg_q,
   output logic               hit,
   output logic               armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     reg_q <= '0;
      else if (wr_en) reg_q <= wdata;
   end

   // The top bit is the enable; a disabled field always counts as agreeing.
   assign armed = reg_q[FIELD_W];
   assign hit   = !armed || (reg_q[FIELD_W-1:0] == cur);
endmodule

// File: rtl/alarm_status_ctl.sv
module alarm_status_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic match,
   input  logic clr_wr,
   input  logic clr_rd,
   output logic alm_q
);
   // A new match wins over any clear request arriving in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                alm_q <= 1'b0;
      else if (match)            alm_q <= 1'b1;
      else if (clr_wr || clr_rd) alm_q <= 1'b0;
   end
endmodule

// File: rtl/alarm_irq_drv.sv
module alarm_irq_drv #(
   parameter int PULSE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic match,
   input  logic alm,
   input  logic pulse_mode,
   output logic irq_n
);
   logic pulse_active;

   generate
      if (PULSE_CYCLES < 1) begin : g_bad
         $error("PULSE_CYCLES must be at least 1");
      end else if (PULSE_CYCLES == 1) begin : g_flop
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= match;
         end
         assign pulse_active = pulse_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (match)          cnt_q <= CNT_W'(PULSE_CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
         end
         assign pulse_active = (cnt_q != '0);
      end
   endgenerate

   assign irq_n = pulse_mode ? !pulse_active : !alm;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int FIELD_W      = 7,
   parameter int PULSE_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic [FIELD_W-1:0] now_sec_i,
   input  logic [FIELD_W-1:0] now_min_i,
   input  logic [FIELD_W-1:0] now_hour_i,
   input  logic [FIELD_W-1:0] now_date_i,
   input  logic [FIELD_W-1:0] now_mon_i,
   input  logic [FIELD_W-1:0] now_dow_i,
   input  logic               reg_wr_i,
   input  logic               reg_rd_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [FIELD_W:0]   reg_wdata_i,
   output logic [FIELD_W:0]   reg_rdata_o,
   input  logic               pulse_mode_i,
   input  logic               auto_clr_i,
   output logic               alm_o,
   output logic               irq_n_o
);
   localparam int REG_W = FIELD_W + 1;

   generate
      if (FIELD_W < 7) begin : g_bad_w
         $error("FIELD_W must hold two BCD digits (>= 7)");
      end
   endgenerate

   logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_all;
   logic [NUM_FIELDS-1:0][REG_W-1:0]   regs;
   logic [NUM_FIELDS-1:0]              hits;
   logic [NUM_FIELDS-1:0]              armed;
   logic                               match_w;
   logic                               status_sel;

   assign now_all = {now_dow_i, now_mon_i, now_date_i,
                     now_hour_i, now_min_i, now_sec_i};

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         alarm_field_cmp #(.FIELD_W(FIELD_W)) cmp_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (reg_wr_i && (reg_addr_i == ADDR_W'(i))),
            .wdata (reg_wdata_i),
            .cur   (now_all[i]),
            .reg_q (regs[i]),
            .hit   (hits[i]),
            .armed (armed[i])
         );
      end
   endgenerate

   assign match_w    = tick_i && (&hits) && (|armed);
   assign status_sel = (reg_addr_i == SLOT_STATUS);

   alarm_status_ctl status_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .match  (match_w),
      .clr_wr (reg_wr_i && status_sel && !reg_wdata_i[0]),
      .clr_rd (reg_rd_i && status_sel && auto_clr_i),
      .alm_q  (alm_o)
   );

   alarm_irq_drv #(.PULSE_CYCLES(PULSE_CYCLES)) irq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .match      (match_w),
      .alm        (alm_o),
      .pulse_mode (pulse_mode_i),
      .irq_n      (irq_n_o)
   );

   always_comb begin
      if (reg_addr_i < ADDR_W'(NUM_FIELDS)) reg_rdata_o = regs[reg_addr_i];
      else if (status_sel)                  reg_rdata_o = {{FIELD_W{1'b0}}, alm_o};
      else                                  reg_rdata_o = '0;
   end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
   parameter int FIELD_W      = 7,
   parameter int PULSE_CYCLES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             reg_wr_i,
   input logic             reg_rd_i,
   input logic [2:0]       reg_addr_i,
   input logic [FIELD_W:0] reg_wdata_i,
   input logic             pulse_mode_i,
   input logic             auto_clr_i,
   input logic             alm_o,
   input logic             irq_n_o,
   input logic             match_w
);
   localparam int RUN_W = $clog2(PULSE_CYCLES + 2) + 1;

   logic wr_clear, rd_clear;
   logic [RUN_W-1:0] run_q;

   assign wr_clear = reg_wr_i && (reg_addr_i == 3'd6) && !reg_wdata_i[0];
   assign rd_clear = reg_rd_i && (reg_addr_i == 3'd6) && auto_clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  run_q <= '0;
      else if (match_w || irq_n_o) run_q <= '0;
      else if (run_q != '1)        run_q <= run_q + RUN_W'(1);
   end

   // R4
   alm_rise_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_o) |-> $past(tick_i));

   // R10
   match_sets_alm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_w |=> alm_o);

   // R6
   wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clear && !match_w) |=> !alm_o);

   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && !match_w) |=> !alm_o);

   // R5
   alm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_o && !wr_clear && !rd_clear) |=> alm_o);

   // R8
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode_i && match_w) |=> !irq_n_o);

   // R8
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode_i && !irq_n_o) |-> (run_q < RUN_W'(PULSE_CYCLES)));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(
   .FIELD_W(FIELD_W),
   .PULSE_CYCLES(PULSE_CYCLES)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_i       (tick_i),
   .reg_wr_i     (reg_wr_i),
   .reg_rd_i     (reg_rd_i),
   .reg_addr_i   (reg_addr_i),
   .reg_wdata_i  (reg_wdata_i),
   .pulse_mode_i (pulse_mode_i),
   .auto_clr_i   (auto_clr_i),
   .alm_o        (alm_o),
   .irq_n_o      (irq_n_o),
   .match_w      (match_w)
);

// File: tb/rtc_alarm_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_irq_tb_top;
   localparam int FW    = 7;
   localparam int PULSE = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [FW-1:0] t_sec = '0, t_min = '0, t_hour = '0, t_date = '0, t_mon = '0, t_dow = '0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [2:0]    addr = 3'd7;
   logic [FW:0]   wdata = '0;
   logic [FW:0]   rdata;
   logic          pmode = 1'b0, aclr = 1'b0;
   logic          alm, irq_n;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   rtc_alarm_irq #(.FIELD_W(FW), .PULSE_CYCLES(PULSE)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .now_sec_i(t_sec), .now_min_i(t_min), .now_hour_i(t_hour),
      .now_date_i(t_date), .now_mon_i(t_mon), .now_dow_i(t_dow),
      .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .pulse_mode_i(pmode), .auto_clr_i(aclr),
      .alm_o(alm), .irq_n_o(irq_n)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [FW:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0; addr = 3'd7;
   endtask

   task automatic rd_status;
      @(negedge clk); rd = 1'b1; addr = 3'd6;
      @(negedge clk); rd = 1'b0; addr = 3'd7;
   endtask

   task automatic peek(input logic [2:0] a, output logic [FW:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
      addr = 3'd7;
   endtask

   task automatic set_time(input logic [FW-1:0] s, mi, h, dt, mo, dw);
      t_sec = s; t_min = mi; t_hour = h; t_date = dt; t_mon = mo; t_dow = dw;
   endtask

   task automatic do_tick;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_regs;
      for (int i = 0; i < 6; i++) wr_reg(3'(i), 8'h00);
      wr_reg(3'd6, 8'h00);
   endtask

   // Count low cycles of irq_n starting at the current sample point
   task automatic measure_pulse(output int n);
      n = 0;
      while (!irq_n && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic test_reset;
      logic [FW:0] d;
      check("R1 alm after reset", alm, 0);
      check("R1 irq_n after reset", irq_n, 1);
      for (int i = 0; i < 6; i++) begin
         peek(3'(i), d);
         check("R1 alarm reg reset value", d, 8'h00);
      end
   endtask

   task automatic test_regs;
      logic [FW:0] d;
      for (int i = 0; i < 6; i++) wr_reg(3'(i), 8'(8'h80 + 8'h11 * i));
      for (int i = 0; i < 6; i++) begin
         peek(3'(i), d);
         check("R2 readback", d, 8'h80 + 8'h11 * i);
      end
      peek(3'd6, d);
      check("R2 status read with alm clear", d, 0);
      clear_regs();
   endtask

   task automatic test_single;
      logic [FW:0] d;
      pmode = 1'b0;
      wr_reg(3'd1, 8'hB0); wr_reg(3'd2, 8'h91); wr_reg(3'd3, 8'h81); wr_reg(3'd4, 8'h81);
      set_time(7'h59, 7'h29, 7'h11, 7'h01, 7'h01, 7'h03);
      do_tick();
      check("R3 minute mismatch no alarm", alm, 0);
      set_time(7'h00, 7'h30, 7'h11, 7'h01, 7'h01, 7'h03);
      idle(3);
      check("R4 no strobe no alarm", alm, 0);
      do_tick();
      check("R4 alm set after strobe", alm, 1);
      check("R5 irq low single mode", irq_n, 0);
      set_time(7'h01, 7'h30, 7'h11, 7'h01, 7'h01, 7'h03);
      idle(4);
      check("R5 alm held", alm, 1);
      check("R5 irq held", irq_n, 0);
      peek(3'd6, d);
      check("R2 status reads alm", d, 1);
      wr_reg(3'd6, 8'h01);
      check("R6 write one ignored", alm, 1);
      wr_reg(3'd6, 8'h00);
      check("R6 write zero clears alm", alm, 0);
      check("R6 irq released", irq_n, 1);
   endtask

   task automatic test_auto;
      set_time(7'h00, 7'h30, 7'h11, 7'h01, 7'h01, 7'h03);
      aclr = 1'b0;
      do_tick();
      check("R7 setup alm", alm, 1);
      rd_status();
      check("R7 read without auto keeps alm", alm, 1);
      aclr = 1'b1;
      rd_status();
      check("R7 read with auto clears alm", alm, 0);
      check("R7 irq released", irq_n, 1);
      aclr = 1'b0;
      clear_regs();
   endtask

   task automatic test_pulse;
      int w;
      wr_reg(3'd0, 8'hB0);
      pmode = 1'b1;
      set_time(7'h30, 7'h05, 7'h02, 7'h03, 7'h04, 7'h01);
      do_tick();
      check("R9 alm set in pulse mode", alm, 1);
      measure_pulse(w);
      check("R8 pulse width", w, PULSE);
      set_time(7'h31, 7'h05, 7'h02, 7'h03, 7'h04, 7'h01);
      do_tick();
      check("R8 no pulse without match", irq_n, 1);
      idle(3);
      set_time(7'h30, 7'h06, 7'h02, 7'h03, 7'h04, 7'h01);
      check("R8 alm still set before repeat", alm, 1);
      do_tick();
      measure_pulse(w);
      check("R8 repeat pulse width", w, PULSE);
      pmode = 1'b0;
      clear_regs();
   endtask

   task automatic test_fields;
      set_time(7'h12, 7'h34, 7'h05, 7'h06, 7'h07, 7'h03);
      do_tick();
      check("R3 no field enabled no match", alm, 0);
      wr_reg(3'd5, 8'h85);
      do_tick();
      check("R3 enabled day mismatch", alm, 0);
      t_dow = 7'h05;
      do_tick();
      check("R3 only enabled day compared", alm, 1);
      wr_reg(3'd6, 8'h00);
   endtask

   task automatic test_priority;
      t_dow = 7'h05;
      @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 3'd6; wdata = 8'h00;
      @(negedge clk); tick = 1'b0; wr = 1'b0; addr = 3'd7;
      check("R10 match beats clearing write", alm, 1);
      aclr = 1'b1;
      @(negedge clk); tick = 1'b1; rd = 1'b1; addr = 3'd6;
      @(negedge clk); tick = 1'b0; rd = 1'b0; addr = 3'd7;
      check("R10 match beats clearing read", alm, 1);
      rd_status();
      check("R10 later read clears", alm, 0);
      aclr = 1'b0;
      clear_regs();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      test_reset();
      test_regs();
      test_single();
      test_auto();
      test_pulse();
      test_fields();
      test_priority();
      summary();
      $finish;
   end
endmodule